// File: doc/BRIEF.md
# Page Access Permission Checker

This block takes the attribute bits that a page-table walk has already fetched and decides whether the access may go ahead. The inputs are the kind of access (read, write or instruction fetch), the privilege index of the requester, the directory-level and table-level attributes, and the paging controls. The block returns a verdict, the size of the page that maps the address, and the bits of a page-fault error code. All results are registered and appear one clock after the input strobe.

There are three privilege indices. User requests need the user bit, and they need the read/write bit for writes. Supervisor requests are subject to two optional checks. The first stops supervisor code from executing user pages. The second stops supervisor code from reading or writing user pages. Supervisor requests are also subject to the write-protect control. A second supervisor index lets the caller lift only the data-access check for a deliberate copy to or from user memory. The execute check and the write-protect check still apply to that index. The table walk, the accessed and dirty flag updates, and address formation happen elsewhere.

Top module: `pgchk_top`

## Requirements
- R1: `out_valid` is `in_valid` delayed by one clock. The verdict, size and error code come from the inputs sampled on that edge, and they hold their values while `in_valid` is low. Synchronous reset clears every output to zero.
- R2: An instruction fetch (`in_acc`=2) faults in every privilege index when the effective no-execute bit is set and `ctl_nxe` and `ctl_pae` are both 1.
- R3: In the user index (`in_priv`=0), an access faults when the effective user bit is clear. A write (`in_acc`=1) faults when the effective read/write bit is clear, whatever the value of `ctl_wp`.
- R4: In the plain supervisor index (`in_priv`=1), a read (`in_acc`=0) or a write to a page whose effective user bit is set faults when `ctl_smap` is 1. A fetch is never stopped by `ctl_smap`.
- R5: In both supervisor indices (1 and 2), a fetch from a page whose effective user bit is set faults when `ctl_smep` is 1.
- R6: In both supervisor indices, a write to a page whose effective read/write bit is clear faults only when `ctl_wp` is 1.
- R7: The override index (`in_priv`=2) skips the `ctl_smap` check and keeps the `ctl_smep` and `ctl_wp` checks.
- R8: Attribute fields are bit 0 read/write, bit 1 user and bit 2 no-execute in both `dir_attr` and `tbl_attr`, with bit 3 of `dir_attr` as the large-page flag. For a small page the effective user and read/write bits are the AND of the two levels, and the no-execute bit is their OR. For a large page only `dir_attr` is used.
- R9: `out_size` is 0 for 4 KiB, 1 for 2 MiB and 2 for 4 MiB. The page is 2 MiB when `ctl_pae`=1 and the large-page flag is set. It is 4 MiB when `ctl_pae`=0 and both the large-page flag and `ctl_pse` are set. Otherwise it is 4 KiB.
- R10: On a fault, error-code bit 0 is 1, bit 1 is set for a write, bit 2 copies `usr_mode`, bit 3 is 0, and bit 4 is set for a fetch when (`ctl_nxe` and `ctl_pae`) or `ctl_smep`. When the access is allowed the error code is all zero.
- R11: The unused privilege index (`in_priv`=3) raises no fault from the privilege checks. Only the no-execute rule of R2 can fault it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 treated as read |
| in_priv | input | 2 | Privilege index: 0 user, 1 supervisor, 2 supervisor with data-access check lifted, 3 unused |
| dir_attr | input | 4 | Directory-level attributes {large, nx, user, rw} |
| tbl_attr | input | 3 | Table-level attributes {nx, user, rw} |
| ctl_smep | input | 1 | Supervisor execute prevention enable |
| ctl_smap | input | 1 | Supervisor data-access prevention enable |
| ctl_pse | input | 1 | Large pages allowed without PAE |
| ctl_pae | input | 1 | Physical address extension mode |
| ctl_wp | input | 1 | Supervisor write-protect enable |
| ctl_nxe | input | 1 | No-execute enable |
| usr_mode | input | 1 | Requester runs in user mode (error-code bit) |
| out_valid | output | 1 | Result strobe |
| out_fault | output | 1 | 1 = protection fault, 0 = allowed |
| out_size | output | 2 | Page size code |
| out_err | output | 5 | Page-fault error code |

## Verification
The decision logic has only one piece of state, the output register. A wrong rule therefore shows at the ports on the first clock edge after the request that exposes it, as a wrong `out_fault`, `out_size` or error-code bit. A stuck or missing register enable shows as results that change while `in_valid` is low, or as a strobe that is not exactly one cycle late. The vector table pairs each enable with its neighbouring rule: SMAP against fetch, the override index against SMEP, and WP against the user index. A single misplaced term in the rule selection therefore flips at least one expected verdict.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    PRV_USR  = 2'd0,
    PRV_SUP  = 2'd1,
    PRV_SOVR = 2'd2,
    PRV_NONE = 2'd3
  } prv_e;

  typedef enum logic [1:0] {
    PSZ_4K = 2'd0,
    PSZ_2M = 2'd1,
    PSZ_4M = 2'd2,
    PSZ_XX = 2'd3
  } psz_e;

  // effective rights after merging the levels
  typedef struct packed {
    logic nx;
    logic usr;
    logic rw;
  } perm_t;

  // attribute field positions shared by both levels
  localparam int A_RW  = 0;
  localparam int A_USR = 1;
  localparam int A_NX  = 2;
  localparam int A_BIG = 3;

  // error-code field positions
  localparam int E_PRES  = 0;
  localparam int E_WR    = 1;
  localparam int E_USR   = 2;
  localparam int E_FETCH = 4;

endpackage

// File: rtl/pgchk_merge.sv
module pgchk_merge
  import pgchk_pkg::*;
#(
  parameter int PERM_W = 3,
  localparam int DIR_W = PERM_W + 1
) (
  input  logic [DIR_W-1:0]  dir_attr,
  input  logic [PERM_W-1:0] tbl_attr,
  input  logic              ctl_pse,
  input  logic              ctl_pae,
  output perm_t             eff,
  output psz_e              size
);

  logic big_pae;
  logic big_pse;
  logic big;

  assign big_pae = ctl_pae & dir_attr[A_BIG];
  assign big_pse = ~ctl_pae & ctl_pse & dir_attr[A_BIG];
  assign big     = big_pae | big_pse;

  always_comb begin
    if (big) begin
      eff.rw  = dir_attr[A_RW];
      eff.usr = dir_attr[A_USR];
      eff.nx  = dir_attr[A_NX];
    end else begin
      eff.rw  = dir_attr[A_RW]  & tbl_attr[A_RW];
      eff.usr = dir_attr[A_USR] & tbl_attr[A_USR];
      eff.nx  = dir_attr[A_NX]  | tbl_attr[A_NX];
    end
  end

  always_comb begin
    if (big_pae)      size = PSZ_2M;
    else if (big_pse) size = PSZ_4M;
    else              size = PSZ_4K;
  end

endmodule

// File: rtl/pgchk_rights.sv
module pgchk_rights
  import pgchk_pkg::*;
(
  input  acc_e  acc,
  input  prv_e  prv,
  input  perm_t eff,
  input  logic  ctl_smep,
  input  logic  ctl_smap,
  input  logic  ctl_wp,
  input  logic  ctl_nxe,
  input  logic  ctl_pae,
  output logic  fault
);

  logic is_wr;
  logic is_ex;
  logic nx_hit;
  logic usr_hit;
  logic smap_hit;
  logic smep_hit;
  logic wp_hit;
  logic prv_hit;

  assign is_wr  = (acc == ACC_WR);
  assign is_ex  = (acc == ACC_EX);

  // no-execute applies to every index
  assign nx_hit = is_ex & ctl_nxe & ctl_pae & eff.nx;

  // user index: user bit and plain read/write
  assign usr_hit  = ~eff.usr | (is_wr & ~eff.rw);
  // supervisor data access to a user page
  assign smap_hit = ctl_smap & ~is_ex & eff.usr;
  // supervisor fetch from a user page
  assign smep_hit = ctl_smep & is_ex & eff.usr;
  // supervisor write to a read-only page
  assign wp_hit   = ctl_wp & is_wr & ~eff.rw;

  always_comb begin
    unique case (prv)
      PRV_USR:  prv_hit = usr_hit;
      PRV_SUP:  prv_hit = smap_hit | smep_hit | wp_hit;
      PRV_SOVR: prv_hit = smep_hit | wp_hit;
      default:  prv_hit = 1'b0;
    endcase
  end

  assign fault = nx_hit | prv_hit;

endmodule

// File: rtl/pgchk_errfmt.sv
module pgchk_errfmt
  import pgchk_pkg::*;
#(
  parameter int ERR_W = 5
) (
  input  logic             fault,
  input  acc_e             acc,
  input  logic             usr_mode,
  input  logic             ctl_nxe,
  input  logic             ctl_pae,
  input  logic             ctl_smep,
  output logic [ERR_W-1:0] err
);

  logic fetch_tag;

  assign fetch_tag = (acc == ACC_EX) & ((ctl_nxe & ctl_pae) | ctl_smep);

  always_comb begin
    err = '0;
    if (fault) begin
      err[E_PRES]  = 1'b1;
      err[E_WR]    = (acc == ACC_WR);
      err[E_USR]   = usr_mode;
      err[E_FETCH] = fetch_tag;
    end
  end

endmodule

// File: rtl/pgchk_top.sv
module pgchk_top
  import pgchk_pkg::*;
#(
  parameter int PERM_W = 3,
  parameter int ERR_W  = 5,
  localparam int DIR_W = PERM_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_acc,
  input  logic [1:0]        in_priv,
  input  logic [DIR_W-1:0]  dir_attr,
  input  logic [PERM_W-1:0] tbl_attr,
  input  logic              ctl_smep,
  input  logic              ctl_smap,
  input  logic              ctl_pse,
  input  logic              ctl_pae,
  input  logic              ctl_wp,
  input  logic              ctl_nxe,
  input  logic              usr_mode,
  output logic              out_valid,
  output logic              out_fault,
  output logic [1:0]        out_size,
  output logic [ERR_W-1:0]  out_err
);

  acc_e             acc;
  prv_e             prv;
  perm_t            eff;
  psz_e             size_c;
  logic             fault_c;
  logic [ERR_W-1:0] err_c;

  assign acc = acc_e'(in_acc);
  assign prv = prv_e'(in_priv);

  pgchk_merge #(.PERM_W(PERM_W)) u_merge (
    .dir_attr (dir_attr),
    .tbl_attr (tbl_attr),
    .ctl_pse  (ctl_pse),
    .ctl_pae  (ctl_pae),
    .eff      (eff),
    .size     (size_c)
  );

  pgchk_rights u_rights (
    .acc      (acc),
    .prv      (prv),
    .eff      (eff),
    .ctl_smep (ctl_smep),
    .ctl_smap (ctl_smap),
    .ctl_wp   (ctl_wp),
    .ctl_nxe  (ctl_nxe),
    .ctl_pae  (ctl_pae),
    .fault    (fault_c)
  );

  pgchk_errfmt #(.ERR_W(ERR_W)) u_err (
    .fault    (fault_c),
    .acc      (acc),
    .usr_mode (usr_mode),
    .ctl_nxe  (ctl_nxe),
    .ctl_pae  (ctl_pae),
    .ctl_smep (ctl_smep),
    .err      (err_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_size  <= '0;
      out_err   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_fault <= fault_c;
        out_size  <= size_c;
        out_err   <= err_c;
      end
    end
  end

  a_r1_strobe_delay: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r1_strobe_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_fault) && $stable(out_err) && $stable(out_size)));

  a_r2_nx_fetch: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_acc == 2'd2 && ctl_nxe && ctl_pae && dir_attr[A_NX])
      |=> out_fault);

  a_r3_user_bit: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_priv == 2'd0 && !dir_attr[A_USR]) |=> out_fault);

  a_r10_present_bit: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_err[E_PRES] == out_fault));

  a_r10_clear_allowed: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fault) |-> (out_err == '0));

  a_r11_unused_index: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_priv == 2'd3 && !(in_acc == 2'd2 && ctl_nxe && ctl_pae))
      |=> !out_fault);

endmodule

// File: tb/sim_pgchk_top.sv
`timescale 1ns/1ps
module sim_pgchk_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [1:0] in_acc;
  logic [1:0] in_priv;
  logic [3:0] dir_attr;
  logic [2:0] tbl_attr;
  logic       ctl_smep, ctl_smap, ctl_pse, ctl_pae, ctl_wp, ctl_nxe;
  logic       usr_mode;
  logic       out_valid;
  logic       out_fault;
  logic [1:0] out_size;
  logic [4:0] out_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pgchk_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_acc(in_acc),
    .in_priv(in_priv), .dir_attr(dir_attr), .tbl_attr(tbl_attr),
    .ctl_smep(ctl_smep), .ctl_smap(ctl_smap), .ctl_pse(ctl_pse),
    .ctl_pae(ctl_pae), .ctl_wp(ctl_wp), .ctl_nxe(ctl_nxe),
    .usr_mode(usr_mode), .out_valid(out_valid), .out_fault(out_fault),
    .out_size(out_size), .out_err(out_err)
  );

  // {req, acc, priv, dir{big,nx,usr,rw}, tbl{nx,usr,rw},
  //  ctl{smep,smap,pse,pae,wp,nxe}, usr_mode, fault, size, err}
  localparam int NV = 23;
  localparam logic [29:0] VEC [NV] = '{
    {4'd3,  2'd0, 2'd0, 4'b0011, 3'b011, 6'b000000, 1'b1, 1'b0, 2'd0, 5'b00000}, // R3 ok
    {4'd3,  2'd0, 2'd0, 4'b0011, 3'b001, 6'b000000, 1'b1, 1'b1, 2'd0, 5'b00101}, // R3 user clear
    {4'd3,  2'd1, 2'd0, 4'b0011, 3'b010, 6'b000000, 1'b1, 1'b1, 2'd0, 5'b00111}, // R3 ro write, wp off
    {4'd6,  2'd1, 2'd1, 4'b0011, 3'b010, 6'b000000, 1'b0, 1'b0, 2'd0, 5'b00000}, // R6 wp off
    {4'd6,  2'd1, 2'd1, 4'b0011, 3'b010, 6'b000010, 1'b0, 1'b1, 2'd0, 5'b00011}, // R6 wp on
    {4'd4,  2'd0, 2'd1, 4'b0011, 3'b011, 6'b010000, 1'b0, 1'b1, 2'd0, 5'b00001}, // R4 read
    {4'd4,  2'd2, 2'd1, 4'b0011, 3'b011, 6'b010000, 1'b0, 1'b0, 2'd0, 5'b00000}, // R4 fetch ignores smap
    {4'd5,  2'd2, 2'd1, 4'b0011, 3'b011, 6'b100000, 1'b0, 1'b1, 2'd0, 5'b10001}, // R5 sup
    {4'd5,  2'd2, 2'd2, 4'b0011, 3'b011, 6'b100000, 1'b0, 1'b1, 2'd0, 5'b10001}, // R5 override
    {4'd7,  2'd0, 2'd2, 4'b0011, 3'b011, 6'b010000, 1'b0, 1'b0, 2'd0, 5'b00000}, // R7 smap skipped
    {4'd7,  2'd1, 2'd2, 4'b0011, 3'b010, 6'b010010, 1'b0, 1'b1, 2'd0, 5'b00011}, // R7 wp kept
    {4'd2,  2'd2, 2'd0, 4'b0011, 3'b111, 6'b000101, 1'b1, 1'b1, 2'd0, 5'b10101}, // R2 user
    {4'd2,  2'd2, 2'd3, 4'b0011, 3'b111, 6'b000101, 1'b0, 1'b1, 2'd0, 5'b10001}, // R2 unused idx
    {4'd2,  2'd2, 2'd0, 4'b0011, 3'b111, 6'b000100, 1'b1, 1'b0, 2'd0, 5'b00000}, // R2 nxe off
    {4'd11, 2'd1, 2'd3, 4'b0001, 3'b010, 6'b110010, 1'b0, 1'b0, 2'd0, 5'b00000}, // R11 write
    {4'd11, 2'd2, 2'd3, 4'b0011, 3'b011, 6'b110010, 1'b0, 1'b0, 2'd0, 5'b00000}, // R11 fetch
    {4'd8,  2'd0, 2'd0, 4'b0001, 3'b011, 6'b000000, 1'b1, 1'b1, 2'd0, 5'b00101}, // R8 dir user clear
    {4'd8,  2'd2, 2'd0, 4'b0111, 3'b011, 6'b000101, 1'b1, 1'b1, 2'd0, 5'b10101}, // R8 nx from dir
    {4'd9,  2'd0, 2'd0, 4'b1011, 3'b000, 6'b000100, 1'b1, 1'b0, 2'd1, 5'b00000}, // R9 2M
    {4'd9,  2'd0, 2'd0, 4'b1011, 3'b000, 6'b001000, 1'b1, 1'b0, 2'd2, 5'b00000}, // R9 4M
    {4'd9,  2'd0, 2'd0, 4'b1011, 3'b000, 6'b000000, 1'b1, 1'b1, 2'd0, 5'b00101}, // R9 no pse -> small
    {4'd10, 2'd2, 2'd0, 4'b0011, 3'b001, 6'b000001, 1'b1, 1'b1, 2'd0, 5'b00101}, // R10 no fetch tag
    {4'd10, 2'd2, 2'd0, 4'b0011, 3'b001, 6'b000101, 1'b1, 1'b1, 2'd0, 5'b10101}  // R10 fetch tag
  };

  task automatic drive(input logic [29:0] v);
    in_valid = 1'b1;
    in_acc   = v[25:24];
    in_priv  = v[23:22];
    dir_attr = v[21:18];
    tbl_attr = v[17:15];
    {ctl_smep, ctl_smap, ctl_pse, ctl_pae, ctl_wp, ctl_nxe} = v[14:9];
    usr_mode = v[8];
  endtask

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual={v%b f%b s%0d e%b} expected={v%b f%b s%0d e%b}",
               tag, act[8], act[7], act[6:5], act[4:0], exp[8], exp[7], exp[6:5], exp[4:0]);
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive('0);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {out_valid, out_fault, out_size, out_err}, 9'b0);
    rst = 1'b0;

    // table walk, back to back
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i][29:26], i),
            {out_valid, out_fault, out_size, out_err},
            {1'b1, VEC[i][7:0]});
    end

    // R1 hold while idle: inputs change but results stay from the last vector
    in_valid = 1'b0;
    in_priv  = 2'd3;
    {ctl_smep, ctl_smap, ctl_pse, ctl_pae, ctl_wp, ctl_nxe} = 6'b0;
    dir_attr = 4'b1011;
    @(negedge clk);
    check("R1 idle hold", {out_valid, out_fault, out_size, out_err}, 9'b0_1_00_10101);
    @(negedge clk);
    check("R1 idle hold 2", {out_valid, out_fault, out_size, out_err}, 9'b0_1_00_10101);

    // R1 single strobe after idle: result appears one cycle later, then drops
    drive(VEC[18]);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 strobe", {out_valid, out_fault, out_size, out_err}, 9'b1_0_01_00000);
    @(negedge clk);
    check("R1 strobe end", {out_valid, out_fault, out_size, out_err}, 9'b0_0_01_00000);

    // R1 synchronous reset clears a faulting result
    drive(VEC[1]);
    @(negedge clk);
    check("R3 before reset", {out_valid, out_fault, out_size, out_err}, 9'b1_1_00_00101);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears", {out_valid, out_fault, out_size, out_err}, 9'b0);
    rst = 1'b0;

    // R8 corner: small page with table-only nx, in the override index, write allowed
    drive({4'd8, 2'd1, 2'd2, 4'b0011, 3'b111, 6'b000111, 1'b0, 1'b0, 2'd0, 5'b0});
    @(negedge clk);
    check("R8 table nx on write", {out_valid, out_fault, out_size, out_err}, 9'b1_0_00_00000);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule